// File: doc/BRIEF.md
# Poison Range Clear Engine

This block holds a small table of poisoned memory ranges and carries out a single command that clears one 64-byte line of poison. Each table slot has a valid bit, a start address, a length and a type tag. A command brings a device physical address and a 64-byte line of replacement data. The engine first rejects any address whose line would run past the end of the device. For an accepted address it asks an external line-writer to store the replacement data, and it does this whether or not the line is poisoned.

Once the write has succeeded, the engine walks the table one slot per cycle, starting at slot 0, looking for the first valid range that covers the address. It retires that range. Any part of the range below or above the cleared line goes back into the table as a new range with the same type. A lower piece reuses the retired slot. An upper piece uses the retired slot when there is no lower piece, and otherwise takes the lowest empty slot. If no slot is empty, the upper piece is dropped and a sticky overflow flag is raised. A seed port fills slots and a read port shows any slot, so the surrounding logic can set up and inspect the table.

Top module: `poison_clear_engine`

## Requirements
- R1: After reset, every slot is invalid, the entry count is 0, the overflow flag is 0 and done is 0.
- R2: A command whose address plus 64 is greater than DEV_SIZE (computed without wrap-around) ends with status 1. It makes no write request and leaves the table unchanged. An address whose line ends exactly at DEV_SIZE is accepted.
- R3: Every accepted command raises a write request that carries the command address and the 512-bit data line. When no valid slot covers the address, the command ends with status 0 and the table is unchanged.
- R4: If the line-writer finishes with its ok input low, the command ends with status 2 and the table is unchanged.
- R5: A slot covers the address when start <= address < start + length. If several valid slots cover it, the lowest-index one is used and the others are left unchanged.
- R6: The covering slot is retired. When the cleared line is the whole range, that slot becomes invalid and the count drops by one.
- R7: When the address is greater than the range start, the retired slot is rewritten with start = original start, length = address - start and the original type.
- R8: When address + 64 is less than the range end, an upper range with start = address + 64, end = original end and the original type is stored. It goes in the retired slot if no lower range was made, and otherwise in the lowest invalid slot.
- R9: When an upper range needs a free slot and none is left, it is dropped and the overflow flag is set. The flag stays set until reset.
- R10: Done is high for exactly one cycle at the end of each command. The status output stays unchanged after that until the next command ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a clear command; sampled only when idle |
| cmdAddr | input | ADDR_W | Device physical address of the line to clear |
| cmdData | input | LINE_BYTES*8 | Replacement data for the line |
| wrReq | output | 1 | Line-write request, held until wrDone |
| wrAddr | output | ADDR_W | Address of the line to write |
| wrData | output | LINE_BYTES*8 | Data to write |
| wrDone | input | 1 | Line-writer finished |
| wrOk | input | 1 | Line-writer result, valid with wrDone |
| done | output | 1 | One-cycle end-of-command pulse |
| status | output | 3 | 0 success, 1 address out of range, 2 write failed |
| ldEn | input | 1 | Seed-port write strobe |
| ldIdx | input | IDX_W | Slot to seed |
| ldValid | input | 1 | Valid bit to store |
| ldStart | input | ADDR_W | Range start to store |
| ldLen | input | ADDR_W | Range length to store |
| ldType | input | TYPE_W | Type tag to store |
| rdIdx | input | IDX_W | Slot to inspect |
| rdValid | output | 1 | Valid bit of the inspected slot |
| rdStart | output | ADDR_W | Start of the inspected slot |
| rdLen | output | ADDR_W | Length of the inspected slot |
| rdType | output | TYPE_W | Type of the inspected slot |
| entryCount | output | CNT_W | Number of valid slots |
| overflow | output | 1 | Sticky flag: an upper range was dropped |

## Verification
The clear is tried in several ways. It is aimed at a range that exactly matches the line, at the bottom and the top of a longer range, at the middle of a range, and at an address no range covers. These cases separate removal alone, the lower piece alone, the upper piece alone and both pieces, and they show which slot each piece lands in. Two ranges that overlap at the same address show that the lowest slot wins. Addresses just inside and just past the device end, plus one that wraps near the top of the address space, test the bounds check. A failing line-writer and a completely full table show the early exit and the overflow path.

// File: rtl/poison_clear_pkg.sv
package poison_clear_pkg;
  typedef enum logic [2:0] {
    ST_OK       = 3'd0,
    ST_BAD_ADDR = 3'd1,
    ST_INT_ERR  = 3'd2
  } status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_WRITE, S_SEARCH, S_SPLIT, S_DONE
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCmd;
    logic searchClr;
    logic searchInc;
    logic doSplit;
  } dp_ctrl_t;
endpackage

// File: rtl/poison_table_dp.sv
module poison_table_dp
  import poison_clear_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LINE_BYTES = 64,
  parameter int DEPTH = 8,
  parameter int TYPE_W = 3,
  parameter logic [ADDR_W:0] DEV_SIZE = 65'h10000,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int DATA_W = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dp_ctrl_t          ctl,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              ldEn,
  input  logic [IDX_W-1:0]  ldIdx,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldStart,
  input  logic [ADDR_W-1:0] ldLen,
  input  logic [TYPE_W-1:0] ldType,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              rdValid,
  output logic [ADDR_W-1:0] rdStart,
  output logic [ADDR_W-1:0] rdLen,
  output logic [TYPE_W-1:0] rdType,
  output logic [ADDR_W-1:0] lineAddr,
  output logic [DATA_W-1:0] lineData,
  output logic              inRange,
  output logic              hit,
  output logic              lastIdx,
  output logic [CNT_W-1:0]  entryCount,
  output logic              overflow
);
  localparam logic [ADDR_W:0] LINE_W = (ADDR_W+1)'(LINE_BYTES);

  logic [DEPTH-1:0]  entValid;
  logic [ADDR_W-1:0] entStart [DEPTH];
  logic [ADDR_W-1:0] entLen   [DEPTH];
  logic [TYPE_W-1:0] entType  [DEPTH];
  logic [IDX_W-1:0]  searchIdx;

  logic [ADDR_W:0] lineEnd, curEnd;
  logic            hasLow, hasUp, freeFound;
  logic [IDX_W-1:0] freeIdx;

  assign lineEnd = {1'b0, lineAddr} + LINE_W;
  assign inRange = (lineEnd <= DEV_SIZE);
  assign curEnd  = {1'b0, entStart[searchIdx]} + {1'b0, entLen[searchIdx]};
  assign hit     = entValid[searchIdx] && (entStart[searchIdx] <= lineAddr)
                   && ({1'b0, lineAddr} < curEnd);
  assign lastIdx = (searchIdx == IDX_W'(DEPTH - 1));
  assign hasLow  = lineAddr > entStart[searchIdx];
  assign hasUp   = lineEnd < curEnd;

  // lowest invalid slot
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!entValid[i]) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lineAddr  <= '0;
      lineData  <= '0;
      searchIdx <= '0;
    end else begin
      if (ctl.latchCmd) begin
        lineAddr <= cmdAddr;
        lineData <= cmdData;
      end
      if (ctl.searchClr)      searchIdx <= '0;
      else if (ctl.searchInc) searchIdx <= searchIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entValid <= '0;
      overflow <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        entStart[i] <= '0;
        entLen[i]   <= '0;
        entType[i]  <= '0;
      end
    end else if (ldEn) begin
      entValid[ldIdx] <= ldValid;
      entStart[ldIdx] <= ldStart;
      entLen[ldIdx]   <= ldLen;
      entType[ldIdx]  <= ldType;
    end else if (ctl.doSplit) begin
      entValid[searchIdx] <= hasLow;
      if (hasLow) entLen[searchIdx] <= lineAddr - entStart[searchIdx];
      if (hasUp) begin
        if (!hasLow) begin
          entValid[searchIdx] <= 1'b1;
          entStart[searchIdx] <= lineEnd[ADDR_W-1:0];
          entLen[searchIdx]   <= ADDR_W'(curEnd - lineEnd);
        end else if (freeFound) begin
          entValid[freeIdx] <= 1'b1;
          entStart[freeIdx] <= lineEnd[ADDR_W-1:0];
          entLen[freeIdx]   <= ADDR_W'(curEnd - lineEnd);
          entType[freeIdx]  <= entType[searchIdx];
        end else begin
          overflow <= 1'b1;
        end
      end
    end
  end

  assign rdValid    = entValid[rdIdx];
  assign rdStart    = entStart[rdIdx];
  assign rdLen      = entLen[rdIdx];
  assign rdType     = entType[rdIdx];
  assign entryCount = CNT_W'($countones(entValid));
endmodule

// File: rtl/poison_clear_ctrl.sv
module poison_clear_ctrl
  import poison_clear_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     inRange,
  input  logic     wrDone,
  input  logic     wrOk,
  input  logic     hit,
  input  logic     lastIdx,
  output dp_ctrl_t ctl,
  output logic     wrReq,
  output logic     done,
  output status_e  status
);
  state_e state, nextState;
  status_e nextStatus;

  always_comb begin
    nextState  = state;
    nextStatus = status;
    ctl        = '0;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.latchCmd = 1'b1;
        nextState    = S_CHECK;
      end
      S_CHECK: begin
        if (!inRange) begin
          nextStatus = ST_BAD_ADDR;
          nextState  = S_DONE;
        end else begin
          nextState = S_WRITE;
        end
      end
      S_WRITE: if (wrDone) begin
        if (!wrOk) begin
          nextStatus = ST_INT_ERR;
          nextState  = S_DONE;
        end else begin
          ctl.searchClr = 1'b1;
          nextState     = S_SEARCH;
        end
      end
      S_SEARCH: begin
        if (hit) begin
          nextState = S_SPLIT;
        end else if (lastIdx) begin
          nextStatus = ST_OK;
          nextState  = S_DONE;
        end else begin
          ctl.searchInc = 1'b1;
        end
      end
      S_SPLIT: begin
        ctl.doSplit = 1'b1;
        nextStatus  = ST_OK;
        nextState   = S_DONE;
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      status <= ST_OK;
    end else begin
      state  <= nextState;
      status <= nextStatus;
    end
  end

  assign wrReq = (state == S_WRITE);
  assign done  = (state == S_DONE);
endmodule

// File: rtl/poison_clear_engine.sv
module poison_clear_engine
  import poison_clear_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LINE_BYTES = 64,
  parameter int DEPTH = 8,
  parameter int TYPE_W = 3,
  parameter logic [ADDR_W:0] DEV_SIZE = 65'h10000,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int DATA_W = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  input  logic              wrDone,
  input  logic              wrOk,
  output logic              done,
  output logic [2:0]        status,
  input  logic              ldEn,
  input  logic [IDX_W-1:0]  ldIdx,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldStart,
  input  logic [ADDR_W-1:0] ldLen,
  input  logic [TYPE_W-1:0] ldType,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              rdValid,
  output logic [ADDR_W-1:0] rdStart,
  output logic [ADDR_W-1:0] rdLen,
  output logic [TYPE_W-1:0] rdType,
  output logic [CNT_W-1:0]  entryCount,
  output logic              overflow
);
  dp_ctrl_t ctl;
  status_e  statusE;
  logic     inRange, hit, lastIdx;

  poison_clear_ctrl u_ctrl (
    .clk, .rst_n, .start, .inRange, .wrDone, .wrOk, .hit, .lastIdx,
    .ctl, .wrReq, .done, .status(statusE)
  );

  poison_table_dp #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .DEPTH(DEPTH),
    .TYPE_W(TYPE_W), .DEV_SIZE(DEV_SIZE)
  ) u_dp (
    .clk, .rst_n, .ctl, .cmdAddr, .cmdData,
    .ldEn, .ldIdx, .ldValid, .ldStart, .ldLen, .ldType,
    .rdIdx, .rdValid, .rdStart, .rdLen, .rdType,
    .lineAddr(wrAddr), .lineData(wrData),
    .inRange, .hit, .lastIdx, .entryCount, .overflow
  );

  assign status = statusE;
endmodule

// File: rtl/poison_clear_checker.sv
module poison_clear_checker #(
  parameter int ADDR_W = 64,
  parameter int LINE_BYTES = 64,
  parameter int DEPTH = 8,
  parameter logic [ADDR_W:0] DEV_SIZE = 65'h10000,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrReq,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              wrDone,
  input logic              wrOk,
  input logic              done,
  input logic [2:0]        status,
  input logic              ldEn,
  input logic [CNT_W-1:0]  entryCount,
  input logic              overflow
);
  // R2: a write is only requested for a line inside the device
  assert_wr_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrReq |-> (({1'b0, wrAddr} + (ADDR_W+1)'(LINE_BYTES)) <= DEV_SIZE));

  // R3: request and its address held until the writer answers
  assert_wr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrReq && !wrDone) |=> (wrReq && $stable(wrAddr)));

  // R4: writer failure ends the command with status 2
  assert_wr_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrReq && wrDone && !wrOk) |=> (done && status == 3'd2));

  // R8: a clear adds at most one slot
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ldEn |=> (entryCount <= $past(entryCount) + 1'b1));

  // R9: overflow is sticky
  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R10: done lasts one cycle, status steady after it
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && $stable(status)));
endmodule

bind poison_clear_engine poison_clear_checker #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .DEPTH(DEPTH), .DEV_SIZE(DEV_SIZE)
) chk (
  .clk, .rst_n, .wrReq, .wrAddr, .wrDone, .wrOk, .done, .status,
  .ldEn, .entryCount, .overflow
);

// File: tb/poison_clear_engine_test.sv
module poison_clear_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 64;
  localparam int DW = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] cmdAddr = '0;
  logic [DW-1:0] cmdData = '0;
  logic wrReq;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;
  logic wrDone = 1'b0, wrOk = 1'b0;
  logic done;
  logic [2:0] status;
  logic ldEn = 1'b0, ldValid = 1'b0;
  logic [2:0] ldIdx = '0, rdIdx = '0;
  logic [AW-1:0] ldStart = '0, ldLen = '0;
  logic [2:0] ldType = '0;
  logic rdValid;
  logic [AW-1:0] rdStart, rdLen;
  logic [2:0] rdType;
  logic [3:0] entryCount;
  logic overflow;

  int total = 0, bad = 0;
  int wrCount = 0;
  bit failNext = 1'b0;
  bit finished = 1'b0;
  logic [AW-1:0] gotAddr;
  logic [DW-1:0] gotData;
  logic [2:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  poison_clear_engine uut (
    .clk, .rst_n, .start, .cmdAddr, .cmdData, .wrReq, .wrAddr, .wrData,
    .wrDone, .wrOk, .done, .status, .ldEn, .ldIdx, .ldValid, .ldStart,
    .ldLen, .ldType, .rdIdx, .rdValid, .rdStart, .rdLen, .rdType,
    .entryCount, .overflow
  );

  task automatic check(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkSlot(input int idx, input bit v, input logic [AW-1:0] s,
                           input logic [AW-1:0] l, input logic [2:0] t, input string tag);
    rdIdx = 3'(idx);
    #1;
    check(rdValid == v, {tag, " valid"}, AW'(rdValid), AW'(v));
    if (v) begin
      check(rdStart == s, {tag, " start"}, rdStart, s);
      check(rdLen == l, {tag, " len"}, rdLen, l);
      check(rdType == t, {tag, " type"}, AW'(rdType), AW'(t));
    end
  endtask

  task automatic loadSlot(input int idx, input logic [AW-1:0] s, input logic [AW-1:0] l, input logic [2:0] t);
    @(negedge clk);
    ldEn = 1'b1; ldIdx = 3'(idx); ldValid = 1'b1; ldStart = s; ldLen = l; ldType = t;
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // driver: push expected status, issue command, wait for done
  task automatic runCmd(input logic [AW-1:0] a, input logic [2:0] expStat);
    expQ.push_back(expStat);
    @(negedge clk);
    cmdAddr = a;
    cmdData = {8{a ^ 64'hC0DE_5A5A_0000_0000}};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R10 done single cycle", AW'(done), 0);
    check(status == expStat, "R10 status held", AW'(status), AW'(expStat));
  endtask

  // monitor: compare status at each done pulse
  initial forever begin
    @(negedge clk);
    if (rst_n && done) begin
      if (expQ.size() == 0) check(1'b0, "R10 unexpected done", 1, 0);
      else begin
        automatic logic [2:0] e = expQ.pop_front();
        check(status == e, "status at done R2/R3/R4", AW'(status), AW'(e));
      end
    end
  end

  // line-writer model: answers after two cycles
  initial forever begin
    @(negedge clk);
    if (wrReq && !wrDone) begin
      @(negedge clk);
      wrDone = 1'b1;
      wrOk = !failNext;
      gotAddr = wrAddr;
      gotData = wrData;
      wrCount++;
      @(negedge clk);
      wrDone = 1'b0;
      wrOk = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(entryCount == 0, "R1 count", AW'(entryCount), 0);
    check(overflow == 0, "R1 overflow", AW'(overflow), 0);
    check(done == 0, "R1 done", AW'(done), 0);
    for (int i = 0; i < 8; i++) checkSlot(i, 0, 0, 0, 0, "R1 slot");

    // R3 line ending exactly at device size, nothing poisoned
    w = wrCount;
    runCmd(64'hFFC0, 3'd0);
    check(wrCount == w + 1, "R3 write issued", AW'(wrCount), AW'(w + 1));
    check(gotAddr == 64'hFFC0, "R3 write addr", gotAddr, 64'hFFC0);
    check(gotData == {8{64'hFFC0 ^ 64'hC0DE_5A5A_0000_0000}}, "R3 write data", gotData[63:0], 64'hFFC0 ^ 64'hC0DE_5A5A_0000_0000);
    check(entryCount == 0, "R3 table unchanged", AW'(entryCount), 0);

    // R2 out of range, and wrap-around
    w = wrCount;
    runCmd(64'h10000, 3'd1);
    runCmd(64'hFFFF_FFFF_FFFF_FFF0, 3'd1);
    check(wrCount == w, "R2 no write", AW'(wrCount), AW'(w));

    // R6 whole-range clear
    loadSlot(2, 64'h1000, 64'h40, 3'd1);
    runCmd(64'h1000, 3'd0);
    checkSlot(2, 0, 0, 0, 0, "R6 retired");
    check(entryCount == 0, "R6 count", AW'(entryCount), 0);

    // R7/R8 middle clear: both pieces
    loadSlot(0, 64'h2000, 64'h100, 3'd2);
    runCmd(64'h2040, 3'd0);
    checkSlot(0, 1, 64'h2000, 64'h40, 3'd2, "R7 lower piece");
    checkSlot(1, 1, 64'h2080, 64'h80, 3'd2, "R8 upper in free slot");
    check(entryCount == 2, "R8 count", AW'(entryCount), 2);
    check(overflow == 0, "R9 no overflow with free slot", AW'(overflow), 0);

    // R6 exact, R8 upper reuses slot when no lower
    runCmd(64'h2000, 3'd0);
    checkSlot(0, 0, 0, 0, 0, "R6 exact clear");
    runCmd(64'h2080, 3'd0);
    checkSlot(1, 1, 64'h20C0, 64'h40, 3'd2, "R8 upper in same slot");

    // R4 writer failure
    loadSlot(3, 64'h3000, 64'h40, 3'd5);
    failNext = 1'b1;
    runCmd(64'h3000, 3'd2);
    failNext = 1'b0;
    checkSlot(3, 1, 64'h3000, 64'h40, 3'd5, "R4 table unchanged");

    // R5 lowest slot wins among overlaps
    loadSlot(4, 64'h4000, 64'h80, 3'd1);
    loadSlot(5, 64'h4000, 64'h40, 3'd3);
    runCmd(64'h4000, 3'd0);
    checkSlot(4, 1, 64'h4040, 64'h40, 3'd1, "R5 first match used");
    checkSlot(5, 1, 64'h4000, 64'h40, 3'd3, "R5 later match untouched");

    // R9 full table
    doReset();
    @(negedge clk);
    check(entryCount == 0, "R1 count after reset", AW'(entryCount), 0);
    for (int i = 0; i < 8; i++) loadSlot(i, 64'h8000 + 64'(i) * 64'h1000, 64'h100, 3'd4);
    runCmd(64'h8040, 3'd0);
    check(overflow == 1, "R9 overflow set", AW'(overflow), 1);
    checkSlot(0, 1, 64'h8000, 64'h40, 3'd4, "R9 lower kept");
    check(entryCount == 8, "R9 count", AW'(entryCount), 8);
    runCmd(64'h9000, 3'd0);
    checkSlot(1, 1, 64'h9040, 64'hC0, 3'd4, "R8 upper after overflow");
    check(overflow == 1, "R9 overflow sticky", AW'(overflow), 1);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R10 all done seen", AW'(expQ.size()), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule